// File: doc/BRIEF.md
# Prioritized nested interrupt arbiter

This block sits between 32 external interrupt request lines and the exception-entry sequencer of a small processor core. It keeps, for every line, a pending flag, an active flag, an enable bit and a two-bit priority. It also works out the current execution priority from the set of active handlers. From these it offers one winning interrupt number and raises a preempt request when that winner is strictly more urgent than the running handler.

The sequencer accepts a request with a take strobe and confirms that the handler has reached its first instruction with a done strobe. While the sequencer is between those two strobes, a more urgent arrival replaces the chosen number (late arrival). When the sequencer reports a handler return, the block tells it in the same cycle whether a pending line should be entered straight away (tail chain). In that case the sequencer skips the restore and re-save of state.

A small register port holds the enable mask and the priority fields. Lower priority values are more urgent, and ties go to the lower line number.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset no line is pending, active or enabled, every priority field reads 0, `execPrio` reads 4 (meaning no active handler), `preemptReq` is 0 and `irqNum` is 0.
- R2: Writing address 0 sets the enable mask (bit n enables line n). Address 1 holds the priorities of lines 0..15 and address 2 those of lines 16..31, with line n at bits [2(n mod 16)+1 : 2(n mod 16)]. `cfgRdata` returns the addressed word in the same cycle.
- R3: Outside an entry, `preemptReq` is 1 only when an eligible line has a priority value numerically below `execPrio`. An equal value does not preempt.
- R4: The winner is the eligible line (pending, enabled, not active) with the smallest priority value. Among equal values, the lowest line number wins. `irqNum` shows the winner, or 0 when there is none.
- R5: A line latches pending on its request whether or not it is enabled. A disabled line is never chosen, and it becomes eligible with its pending flag intact once it is enabled again.
- R6: `entryStart` latches the current winner, and `irqNum` holds it during the entry. `entryDone` clears that line's pending flag and marks it active.
- R7: During an entry, an eligible line with a strictly smaller priority value than the selected one replaces the selection one cycle after it becomes pending. Lines of equal or lower urgency leave the selection unchanged.
- R8: `execPrio` equals the smallest priority value among active lines, or 4 when none is active. A return clears the returned line's active flag.
- R9: In a cycle with `retValid`, `tailChain` is 1 exactly when an eligible line is more urgent than the execution priority that remains once the returning line is excluded.
- R10: A line whose request is still asserted when its handler returns becomes pending again one cycle after the return. A line whose request has dropped stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 32 | Interrupt request lines |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration word address |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data for `cfgAddr` |
| entryStart | input | 1 | Sequencer takes the offered interrupt |
| entryDone | input | 1 | Handler reached its first instruction |
| retValid | input | 1 | A handler returns in this cycle |
| retNum | input | 5 | Number of the returning handler |
| irqNum | output | 5 | Offered or selected interrupt number |
| preemptReq | output | 1 | Winner beats the current execution priority |
| tailChain | output | 1 | Enter the next handler directly on this return |
| execPrio | output | 3 | Current execution priority, 4 when idle |

## Verification
The hardest situation to reach is a late arrival. The bench has to hold the sequencer between its take and done strobes while a fresh, more urgent request reaches the pending set. To get there, it starts an entry for a mid-priority line, holds off `entryDone`, and first raises a less urgent line so that the selection must stay put. It then raises the most urgent line and expects the swap two cycles later. The same most urgent line is left asserted across its own return, so the level re-pend and the tail-chain decision both fall out of a single sequence.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int NUM_IRQ       = 32;
  localparam int PRIO_W        = 2;
  localparam int IDX_W         = $clog2(NUM_IRQ);
  localparam int LEVELS        = 1 << PRIO_W;
  localparam int EPRIO_W       = PRIO_W + 1;
  localparam int CFG_DW        = 32;
  localparam int PRIO_PER_WORD = CFG_DW / PRIO_W;
  localparam int PRIO_WORDS    = (NUM_IRQ + PRIO_PER_WORD - 1) / PRIO_PER_WORD;
  localparam int CFG_AW        = $clog2(PRIO_WORDS + 1);

  typedef enum logic {ST_IDLE, ST_ENTRY} seqState_t;

  typedef struct packed {
    logic             ackEn;
    logic [IDX_W-1:0] ackNum;
  } ctlStrobe_t;
endpackage

// File: rtl/irqarb_lsb.sv
module irqarb_lsb #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqarb_datapath.sv
module irqarb_datapath
  import irqarb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [CFG_DW-1:0]  cfgWdata,
  output logic [CFG_DW-1:0]  cfgRdata,
  input  logic               retValid,
  input  logic [IDX_W-1:0]   retNum,
  input  ctlStrobe_t         strobe,
  output logic               winValid,
  output logic [IDX_W-1:0]   winNum,
  output logic [PRIO_W-1:0]  winPrio,
  output logic [EPRIO_W-1:0] execPrio,
  output logic [EPRIO_W-1:0] execPrioAfterRet
);
  localparam logic [EPRIO_W-1:0] NONE = EPRIO_W'(LEVELS);

  logic [NUM_IRQ-1:0] pending, active, enable;
  logic [PRIO_W-1:0]  prioTab [NUM_IRQ];
  logic [NUM_IRQ-1:0] lvlMask [LEVELS];
  logic [NUM_IRQ-1:0] ackMask, retMask, cand, winMask, activeRest;
  logic [LEVELS-1:0]  candHit, actHit, restHit;
  logic               actFound, restFound, winFound;
  logic [PRIO_W-1:0]  actLvl, restLvl;

  assign ackMask = strobe.ackEn ? (NUM_IRQ'(1) << strobe.ackNum) : '0;
  assign retMask = retValid ? (NUM_IRQ'(1) << retNum) : '0;

  // enable register
  always_ff @(posedge clk) begin
    if (!rstN) enable <= '0;
    else if (cfgWe && cfgAddr == '0) enable <= cfgWdata[NUM_IRQ-1:0];
  end

  // per-line priority fields
  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
      localparam int WORD = i / PRIO_PER_WORD + 1;
      localparam int SLOT = i % PRIO_PER_WORD;
      always_ff @(posedge clk) begin
        if (!rstN) prioTab[i] <= '0;
        else if (cfgWe && cfgAddr == CFG_AW'(WORD))
          prioTab[i] <= cfgWdata[SLOT*PRIO_W +: PRIO_W];
      end
    end
  endgenerate

  always_comb begin
    cfgRdata = '0;
    if (cfgAddr == '0) cfgRdata[NUM_IRQ-1:0] = enable;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cfgAddr == CFG_AW'(i / PRIO_PER_WORD + 1))
        cfgRdata[(i % PRIO_PER_WORD)*PRIO_W +: PRIO_W] = prioTab[i];
    end
  end

  // pending and active state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      active  <= '0;
    end else begin
      pending <= (pending | (irqReq & ~active)) & ~ackMask;
      active  <= (active | ackMask) & ~retMask;
    end
  end

  // level masks and per-level hit vectors
  assign cand       = pending & enable & ~active;
  assign activeRest = active & ~retMask;
  generate
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        assign lvlMask[l][i] = (prioTab[i] == PRIO_W'(l));
      end
      assign candHit[l] = |(cand & lvlMask[l]);
      assign actHit[l]  = |(active & lvlMask[l]);
      assign restHit[l] = |(activeRest & lvlMask[l]);
    end
  endgenerate

  irqarb_lsb #(.W(LEVELS)) u_winLvl (.vec(candHit), .found(winValid), .idx(winPrio));
  assign winMask = cand & lvlMask[winPrio];
  irqarb_lsb #(.W(NUM_IRQ)) u_winIdx (.vec(winMask), .found(winFound), .idx(winNum));
  irqarb_lsb #(.W(LEVELS)) u_actLvl (.vec(actHit), .found(actFound), .idx(actLvl));
  irqarb_lsb #(.W(LEVELS)) u_restLvl (.vec(restHit), .found(restFound), .idx(restLvl));

  assign execPrio         = actFound  ? {1'b0, actLvl}  : NONE;
  assign execPrioAfterRet = restFound ? {1'b0, restLvl} : NONE;

  // R4: an offered winner is pending, enabled and not already running
  a_r4_winner_eligible: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (winFound && pending[winNum] && enable[winNum] && !active[winNum]));

  // R6: acknowledge marks the line active and clears its pending flag
  a_r6_ack_marks_active: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackEn |=> (active[$past(strobe.ackNum)] && !pending[$past(strobe.ackNum)]));

  // R5: pending never drops except through an acknowledge
  a_r5_pending_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(pending) & ~pending)) |-> $past(strobe.ackEn));

  // R8: execution priority reads "none" exactly when nothing is active
  a_r8_exec_none_iff_idle: assert property (@(posedge clk) disable iff (!rstN)
    (execPrio == NONE) == (active == '0));
endmodule

// File: rtl/irqarb_control.sv
module irqarb_control
  import irqarb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               entryStart,
  input  logic               entryDone,
  input  logic               retValid,
  input  logic               winValid,
  input  logic [IDX_W-1:0]   winNum,
  input  logic [PRIO_W-1:0]  winPrio,
  input  logic [EPRIO_W-1:0] execPrio,
  input  logic [EPRIO_W-1:0] execPrioAfterRet,
  output ctlStrobe_t         strobe,
  output logic [IDX_W-1:0]   irqNum,
  output logic               preemptReq,
  output logic               tailChain
);
  seqState_t         state;
  logic [IDX_W-1:0]  selNum;
  logic [PRIO_W-1:0] selPrio;
  logic              lateWins;

  assign lateWins = winValid && (winPrio < selPrio);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selNum  <= '0;
      selPrio <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (entryStart) begin
          state   <= ST_ENTRY;
          selNum  <= winNum;
          selPrio <= winPrio;
        end
        ST_ENTRY: begin
          if (entryDone) state <= ST_IDLE;
          else if (lateWins) begin
            selNum  <= winNum;
            selPrio <= winPrio;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.ackEn  = (state == ST_ENTRY) && entryDone;
    strobe.ackNum = selNum;
    irqNum        = (state == ST_ENTRY) ? selNum : (winValid ? winNum : '0);
    preemptReq    = (state == ST_IDLE) && winValid && ({1'b0, winPrio} < execPrio);
    tailChain     = (state == ST_IDLE) && retValid && winValid
                    && ({1'b0, winPrio} < execPrioAfterRet);
  end

  // R7: while entry is in progress the selection can only become more urgent
  a_r7_sel_never_worse: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ENTRY && !entryDone) |=> (state == ST_ENTRY && selPrio <= $past(selPrio)));

  // R6: the offered number is frozen during entry unless a late arrival wins
  a_r6_sel_stable: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ENTRY && !entryDone && !lateWins) |=> $stable(irqNum));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import irqarb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [CFG_DW-1:0]  cfgWdata,
  output logic [CFG_DW-1:0]  cfgRdata,
  input  logic               entryStart,
  input  logic               entryDone,
  input  logic               retValid,
  input  logic [IDX_W-1:0]   retNum,
  output logic [IDX_W-1:0]   irqNum,
  output logic               preemptReq,
  output logic               tailChain,
  output logic [EPRIO_W-1:0] execPrio
);
  ctlStrobe_t         strobe;
  logic               winValid;
  logic [IDX_W-1:0]   winNum;
  logic [PRIO_W-1:0]  winPrio;
  logic [EPRIO_W-1:0] execPrioAfterRet;

  irqarb_datapath u_dp (
    .clk, .rstN, .irqReq, .cfgWe, .cfgAddr, .cfgWdata, .cfgRdata,
    .retValid, .retNum, .strobe, .winValid, .winNum, .winPrio,
    .execPrio, .execPrioAfterRet
  );

  irqarb_control u_ctl (
    .clk, .rstN, .entryStart, .entryDone, .retValid, .winValid, .winNum,
    .winPrio, .execPrio, .execPrioAfterRet, .strobe, .irqNum,
    .preemptReq, .tailChain
  );
endmodule

// File: tb/sim_prio_irq_arbiter.sv
`timescale 1ns/1ps
module sim_prio_irq_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqReq = '0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        entryStart = 1'b0, entryDone = 1'b0, retValid = 1'b0;
  logic [4:0]  retNum = '0;
  logic [4:0]  irqNum;
  logic        preemptReq, tailChain;
  logic [2:0]  execPrio;

  prio_irq_arbiter u0 (.*);

  always #2 clk = ~clk;

  typedef enum int {F_NUM, F_PRE, F_EP, F_TC, F_RD} field_t;
  typedef struct {string tag; field_t fld; int expv;} item_t;
  item_t scoreQ[$];
  int    nChecks = 0, nErrors = 0;
  bit    done = 0;
  int    prioArr [32];

  task automatic expectOn(string tag, field_t fld, int expv);
    item_t it;
    it.tag = tag; it.fld = fld; it.expv = expv;
    scoreQ.push_back(it);
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic cfgWr(logic [1:0] a, logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    cyc();
    cfgWe = 1'b0; cfgAddr = '0;
  endtask

  function automatic logic [31:0] packWord(int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 16; k++) r[2*k +: 2] = 2'(prioArr[w*16 + k]);
    return r;
  endfunction

  // monitor: pops and compares queued expectations at each falling edge
  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      item_t it;
      int act;
      it = scoreQ.pop_front();
      case (it.fld)
        F_NUM:   act = int'(irqNum);
        F_PRE:   act = int'(preemptReq);
        F_EP:    act = int'(execPrio);
        F_TC:    act = int'(tailChain);
        default: act = int'(cfgRdata);
      endcase
      nChecks++;
      if (act != it.expv) begin
        nErrors++;
        $display("FAIL %s field=%0d actual=%0h expected=%0h", it.tag, it.fld, act, it.expv);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) prioArr[i] = 3;
    prioArr[3] = 2; prioArr[5] = 1; prioArr[7] = 2; prioArr[9] = 1; prioArr[20] = 0;

    cyc(3);
    rstN = 1'b1;
    // R1 reset state
    expectOn("R1", F_EP, 4); expectOn("R1", F_PRE, 0);
    expectOn("R1", F_RD, 0); expectOn("R1", F_NUM, 0);
    cyc();
    cfgAddr = 2'd1; expectOn("R1", F_RD, 0); cyc(); cfgAddr = '0;

    // R2 configuration write and readback
    cfgWr(2'd0, 32'hFFFF_FFFF);
    cfgWr(2'd1, packWord(0));
    cfgWr(2'd2, packWord(1));
    cfgAddr = 2'd0; expectOn("R2", F_RD, 32'hFFFF_FFFF); cyc();
    cfgAddr = 2'd1; expectOn("R2", F_RD, 32'hFFF7_B7BF); cyc();
    cfgAddr = 2'd2; expectOn("R2", F_RD, 32'hFFFF_FCFF); cyc();
    cfgAddr = 2'd0;

    // R4 lowest value then lowest number; R3 preempt from idle
    irqReq = (32'd1 << 9) | (32'd1 << 5) | (32'd1 << 7);
    cyc(); irqReq = '0;
    expectOn("R4", F_NUM, 5); expectOn("R3", F_PRE, 1); cyc();

    // R6 entry of line 5
    entryStart = 1'b1; cyc(); entryStart = 1'b0;
    expectOn("R6", F_NUM, 5); cyc();
    entryDone = 1'b1; cyc(); entryDone = 1'b0;
    expectOn("R6", F_EP, 1); expectOn("R4", F_NUM, 9); expectOn("R3", F_PRE, 0); cyc();

    // R3 strictly more urgent preempts; nest line 20
    irqReq = 32'd1 << 20; cyc(); irqReq = '0;
    expectOn("R3", F_PRE, 1); expectOn("R3", F_NUM, 20); cyc();
    entryStart = 1'b1; cyc(); entryStart = 1'b0;
    entryDone = 1'b1; cyc(); entryDone = 1'b0;
    expectOn("R8", F_EP, 0); cyc();

    // R9 return without and with tail chain; R8 priority unwinds
    retValid = 1'b1; retNum = 5'd20; expectOn("R9", F_TC, 0); cyc(); retValid = 1'b0;
    expectOn("R8", F_EP, 1); cyc();
    retValid = 1'b1; retNum = 5'd5; expectOn("R9", F_TC, 1); cyc(); retValid = 1'b0;
    expectOn("R8", F_EP, 4); expectOn("R3", F_PRE, 1); expectOn("R4", F_NUM, 9); cyc();

    // R7 late arrival during entry of line 9
    entryStart = 1'b1; cyc(); entryStart = 1'b0;
    expectOn("R6", F_NUM, 9); cyc();
    irqReq = 32'd1 << 3; cyc(2);
    expectOn("R7", F_NUM, 9); cyc();
    irqReq = 32'd1 << 20; cyc(2);
    expectOn("R7", F_NUM, 20); cyc();
    entryDone = 1'b1; cyc(); entryDone = 1'b0;
    expectOn("R6", F_EP, 0); cyc();

    // R10 level still high across the return of line 20
    retValid = 1'b1; retNum = 5'd20;
    expectOn("R9", F_TC, 1); expectOn("R10", F_NUM, 9); cyc(); retValid = 1'b0;
    expectOn("R10", F_NUM, 20); expectOn("R10", F_PRE, 1); cyc();
    irqReq = '0;
    entryStart = 1'b1; cyc(); entryStart = 1'b0;
    entryDone = 1'b1; cyc(); entryDone = 1'b0;
    retValid = 1'b1; retNum = 5'd20; cyc(); retValid = 1'b0;
    cyc();
    expectOn("R10", F_NUM, 9); expectOn("R8", F_EP, 4); cyc();

    // R5 disabled line keeps pending but is skipped
    cfgWr(2'd0, ~(32'd1 << 9));
    expectOn("R5", F_NUM, 3); cyc();
    cfgWr(2'd0, 32'hFFFF_FFFF);
    expectOn("R5", F_NUM, 9); cyc();

    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule